// File: doc/BRIEF.md
# MII Receive Nibble Formatter

This block turns the decoded receive symbol stream of a 100 Mb/s Ethernet PHY into the MII receive signals `rxd`, `rx_dv` and `rx_er`. A 4B/5B decoder ahead of it delivers one symbol per nibble period. Each symbol carries a kind (idle, start-of-stream, data, end-of-stream, invalid) and a 4-bit nibble. The formatter opens a stream on a start-of-stream marker and forwards the data nibbles. It closes the stream cleanly on an end-of-stream marker. Faults inside the stream are reported on the MII with a substitute nibble and `rx_er`.

A stored strip setting can suppress the run of `5h` preamble nibbles, so that the MII frame starts at the SFD pair (`5h` then `Dh`). A compatibility input forces stripping off. While that input is high, it also blocks writes to the stored strip bit. Invalid symbols are reported as code errors, and the substitute nibble is chosen by a select input; a separate report enable overrides that choice. Two consecutive idles inside a stream are reported as a premature end, which has its own substitute select.

The control is a three-state machine. `ST_IDLE` waits for a start-of-stream marker and then moves to `ST_STRIP` when stripping is in force, or to `ST_DATA` otherwise. `ST_STRIP` holds back `5h` nibbles. It moves to `ST_DATA` on the SFD pair, on any other data nibble, or on a code error. `ST_DATA` forwards nibbles. Both stream states return to `ST_IDLE` on an end-of-stream marker or on a premature end.

Top module: `mii_rx_formatter`

## Requirements
- R1: While `rst_n` is low and after reset, `rx_dv`, `rx_er` and `rxd` are 0, and the stored strip bit is 0.
- R2: Symbol kinds on `sym_kind` are coded as 0 idle, 1 start-of-stream, 2 data, 3 end-of-stream, 4 invalid. With stripping off, each data nibble after a start-of-stream appears on `rxd` with `rx_dv` high, in order, two clock cycles after it is presented. The start-of-stream symbol itself produces no output.
- R3: An end-of-stream symbol inside a stream drops `rx_dv` in its own output cycle, with `rx_er` low.
- R4: With stripping in force, `5h` data nibbles after start-of-stream are withheld (`rx_dv` low). When a `5h` is followed by `Dh`, that `5h` and then the `Dh` are output with `rx_dv` high, and the frame data follows.
- R5: With stripping in force, the first data nibble other than `5h` ends suppression and is forwarded.
- R6: While `compat_mode` is high, stripping is not applied, whatever the stored strip bit holds.
- R7: A strip write (`cfg_wr` with `cfg_strip`) made while `compat_mode` is high leaves the stored strip bit unchanged.
- R8: With `ce_report_en` high, an invalid symbol inside a stream gives one cycle with `rx_dv` and `rx_er` high and `rxd` = 5h if `ce_sel` is 1, else 6h. The stream then continues.
- R9: With `ce_report_en` low, an invalid symbol gives `rx_dv` high, `rx_er` low, and `rxd` equal to that symbol's nibble.
- R10: Two idle symbols in a row inside a stream give one cycle with `rx_dv` and `rx_er` high and `rxd` = 4h if `pe_sel` is 1, else 6h. `rx_dv` is low from the next cycle on, and data is ignored until the next start-of-stream.
- R11: A single idle inside a stream that is not followed by a second idle is handled as a code error under R8/R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_kind | input | 3 | Kind of the decoded symbol (R2 coding) |
| sym_nib | input | 4 | Decoded nibble of the symbol |
| cfg_wr | input | 1 | Write strobe for the stored strip bit |
| cfg_strip | input | 1 | Value written to the strip bit |
| compat_mode | input | 1 | Forces stripping off and blocks strip writes |
| ce_sel | input | 1 | Code-error substitute select (1: 5h, 0: 6h) |
| pe_sel | input | 1 | Premature-end substitute select (1: 4h, 0: 6h) |
| ce_report_en | input | 1 | Enables code-error reporting |
| rxd | output | 4 | MII receive nibble |
| rx_dv | output | 1 | MII receive data valid |
| rx_er | output | 1 | MII receive error |

## Verification
Every symbol takes two register stages to reach the MII. One stage holds it, so that its successor can be seen (SFD pair, double idle), and one stage registers the outputs. Each result is therefore due two cycles after its symbol is presented. A premature end takes effect in the output cycle of the first idle, and `rx_dv` falls one cycle after that. The bench drives symbols and records the outputs at falling edges into a per-scenario log. It then checks the log entry at the symbol's index plus two, so no check depends on process order at the rising edge.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        SYM_IDLE = 3'd0,
        SYM_SSD  = 3'd1,
        SYM_DATA = 3'd2,
        SYM_ESD  = 3'd3,
        SYM_BAD  = 3'd4
    } sym_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STRIP = 2'd1,
        ST_DATA  = 2'd2
    } rx_state_e;

    localparam logic [NIB_W-1:0] NIB_PRE      = 4'h5;
    localparam logic [NIB_W-1:0] NIB_SFD      = 4'hD;
    localparam logic [NIB_W-1:0] CODE_PE_ALT  = 4'h4;
    localparam logic [NIB_W-1:0] CODE_CE_ALT  = 4'h5;
    localparam logic [NIB_W-1:0] CODE_DEFAULT = 4'h6;

endpackage

// File: rtl/mii_rx_strip_cfg.sv
module mii_rx_strip_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_strip,
    input  logic compat_mode,
    output logic strip_on
);

    logic strip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strip_q <= 1'b0;
        end else if (cfg_wr && !compat_mode) begin
            strip_q <= cfg_strip;
        end
    end

    assign strip_on = strip_q && !compat_mode;

    // R7: a write attempted under compatibility mode leaves the bit alone
    p_strip_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        compat_mode |=> (strip_q == $past(strip_q)));

endmodule

// File: rtl/mii_rx_errcode.sv
module mii_rx_errcode
    import mii_rx_pkg::*;
(
    input  logic             ce_sel,
    input  logic             pe_sel,
    output logic [NIB_W-1:0] ce_code,
    output logic [NIB_W-1:0] pe_code
);

    always_comb begin
        ce_code = ce_sel ? CODE_CE_ALT : CODE_DEFAULT;
        pe_code = pe_sel ? CODE_PE_ALT : CODE_DEFAULT;
    end

endmodule

// File: rtl/mii_rx_fsm.sv
module mii_rx_fsm
    import mii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_W-1:0] in_kind,
    input  logic [NIB_W-1:0]  in_nib,
    input  logic              strip_on,
    input  logic              ce_report_en,
    input  logic [NIB_W-1:0]  ce_code,
    input  logic [NIB_W-1:0]  pe_code,
    output logic [NIB_W-1:0]  rxd,
    output logic              rx_dv,
    output logic              rx_er
);

    logic [KIND_W-1:0] hold_kind;
    logic [NIB_W-1:0]  hold_nib;
    rx_state_e         state_q, state_d;
    logic              dv_d, er_d, pe_d, pe_q;
    logic [NIB_W-1:0]  rxd_d;
    logic              in_stream, hold_idle, next_idle, next_sfd;

    // look-ahead stage: holds one symbol so its successor is visible
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_kind <= SYM_IDLE;
            hold_nib  <= '0;
        end else begin
            hold_kind <= in_kind;
            hold_nib  <= in_nib;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_stream = (state_q != ST_IDLE);
    assign hold_idle = (hold_kind == SYM_IDLE);
    assign next_idle = (in_kind == SYM_IDLE);
    assign next_sfd  = (in_kind == SYM_DATA) && (in_nib == NIB_SFD);

    always_comb begin
        state_d = state_q;
        dv_d    = 1'b0;
        er_d    = 1'b0;
        pe_d    = 1'b0;
        rxd_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_kind == SYM_SSD) begin
                    state_d = strip_on ? ST_STRIP : ST_DATA;
                end
            end
            ST_STRIP, ST_DATA: begin
                if (hold_idle && next_idle) begin
                    dv_d    = 1'b1;
                    er_d    = 1'b1;
                    pe_d    = 1'b1;
                    rxd_d   = pe_code;
                    state_d = ST_IDLE;
                end else if (hold_kind == SYM_ESD) begin
                    state_d = ST_IDLE;
                end else if (hold_kind == SYM_DATA) begin
                    if (state_q == ST_STRIP && hold_nib == NIB_PRE) begin
                        if (next_sfd) begin
                            dv_d    = 1'b1;
                            rxd_d   = hold_nib;
                            state_d = ST_DATA;
                        end
                    end else begin
                        dv_d    = 1'b1;
                        rxd_d   = hold_nib;
                        state_d = ST_DATA;
                    end
                end else begin
                    dv_d    = 1'b1;
                    er_d    = ce_report_en;
                    rxd_d   = ce_report_en ? ce_code : hold_nib;
                    state_d = ST_DATA;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
            rxd   <= '0;
            pe_q  <= 1'b0;
        end else begin
            rx_dv <= dv_d;
            rx_er <= er_d;
            rxd   <= rxd_d;
            pe_q  <= pe_d;
        end
    end

    // R10: valid drops in the cycle after a premature-end report
    p_pe_drops_dv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pe_q |=> !rx_dv);

    // R8: an error nibble is only ever shown inside a valid frame
    p_er_needs_dv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv);

    // R8, R10: any error nibble is one of the substitute codes
    p_er_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> (rxd == CODE_PE_ALT || rxd == CODE_CE_ALT || rxd == CODE_DEFAULT));

    // R3: end-of-stream closes the frame without an error
    p_esd_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stream && hold_kind == SYM_ESD && !(hold_idle && next_idle)) |=> (!rx_dv && !rx_er));

    // R6: no state is left in strip mode while the stripping input is off
    p_no_strip_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !strip_on) |=> (state_q != ST_STRIP));

endmodule

// File: rtl/mii_rx_formatter.sv
module mii_rx_formatter
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       sym_kind,
    input  logic [3:0]       sym_nib,
    input  logic             cfg_wr,
    input  logic             cfg_strip,
    input  logic             compat_mode,
    input  logic             ce_sel,
    input  logic             pe_sel,
    input  logic             ce_report_en,
    output logic [3:0]       rxd,
    output logic             rx_dv,
    output logic             rx_er
);

    logic             strip_on;
    logic [NIB_W-1:0] ce_code, pe_code;

    mii_rx_strip_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_strip   (cfg_strip),
        .compat_mode (compat_mode),
        .strip_on    (strip_on)
    );

    mii_rx_errcode u_codes (
        .ce_sel  (ce_sel),
        .pe_sel  (pe_sel),
        .ce_code (ce_code),
        .pe_code (pe_code)
    );

    mii_rx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_kind      (sym_kind),
        .in_nib       (sym_nib),
        .strip_on     (strip_on),
        .ce_report_en (ce_report_en),
        .ce_code      (ce_code),
        .pe_code      (pe_code),
        .rxd          (rxd),
        .rx_dv        (rx_dv),
        .rx_er        (rx_er)
    );

endmodule

// File: tb/mii_rx_formatter_tb.sv
module mii_rx_formatter_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [2:0] K_IDLE = 3'd0, K_SSD = 3'd1, K_DATA = 3'd2,
                           K_ESD = 3'd3, K_BAD = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sym_kind = K_IDLE;
    logic [3:0] sym_nib = 4'h0;
    logic       cfg_wr = 1'b0, cfg_strip = 1'b0, compat_mode = 1'b0;
    logic       ce_sel = 1'b0, pe_sel = 1'b0, ce_report_en = 1'b1;
    logic [3:0] rxd;
    logic       rx_dv, rx_er;

    int tests = 0;
    int fails = 0;
    int n = 0;
    logic       obs_dv [64];
    logic       obs_er [64];
    logic [3:0] obs_d  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_rx_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .sym_kind(sym_kind), .sym_nib(sym_nib),
        .cfg_wr(cfg_wr), .cfg_strip(cfg_strip), .compat_mode(compat_mode),
        .ce_sel(ce_sel), .pe_sel(pe_sel), .ce_report_en(ce_report_en),
        .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er)
    );

    // record outputs at the falling edge, then present the next symbol
    task automatic send(input logic [2:0] k, input logic [3:0] v);
        @(negedge clk);
        if (n < 64) begin
            obs_dv[n] = rx_dv; obs_er[n] = rx_er; obs_d[n] = rxd;
        end
        n++;
        sym_kind = k; sym_nib = v;
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) send(K_IDLE, 4'h0);
    endtask

    task automatic chk(input int idx, input logic edv, input logic eer,
                       input logic [3:0] ed, input bit cmp_d, input string tag);
        tests++;
        if (obs_dv[idx] !== edv || obs_er[idx] !== eer || (cmp_d && obs_d[idx] !== ed)) begin
            fails++;
            $display("FAIL %s at log %0d: got dv=%b er=%b rxd=%h, expected dv=%b er=%b rxd=%h",
                     tag, idx, obs_dv[idx], obs_er[idx], obs_d[idx], edv, eer, ed);
        end
    endtask

    task automatic write_strip(input logic v);
        @(negedge clk); cfg_wr = 1'b1; cfg_strip = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        tests++;
        if (rx_dv !== 1'b0 || rx_er !== 1'b0 || rxd !== 4'h0) begin
            fails++;
            $display("FAIL R1 in reset: got dv=%b er=%b rxd=%h, expected 0/0/0", rx_dv, rx_er, rxd);
        end
        rst_n = 1'b1;
        n = 0;
        flush();
        chk(3, 0, 0, 4'h0, 1, "R1 after reset");
    endtask

    task automatic t_plain();
        n = 0;
        send(K_SSD, 0); send(K_DATA, 4'h3); send(K_DATA, 4'hA); send(K_DATA, 4'h0);
        send(K_ESD, 0); flush();
        chk(2, 0, 0, 0, 0, "R2 ssd silent");
        chk(3, 1, 0, 4'h3, 1, "R2 nibble 1");
        chk(4, 1, 0, 4'hA, 1, "R2 nibble 2");
        chk(5, 1, 0, 4'h0, 1, "R2 nibble 3");
        chk(6, 0, 0, 0, 0, "R3 esd clean");
    endtask

    // preamble of 15 fives then D; strip_expected selects R4 vs R6/R7 view
    task automatic t_preamble(input bit strip_expected, input string tag);
        n = 0;
        send(K_SSD, 0);
        for (int i = 0; i < 15; i++) send(K_DATA, 4'h5);
        send(K_DATA, 4'hD); send(K_DATA, 4'h1); send(K_DATA, 4'h2);
        send(K_ESD, 0); flush();
        if (strip_expected) begin
            chk(3, 0, 0, 0, 0, {tag, " first 5h withheld"});
            chk(16, 0, 0, 0, 0, {tag, " 14th 5h withheld"});
            chk(17, 1, 0, 4'h5, 1, {tag, " SFD 5h kept"});
        end else begin
            chk(3, 1, 0, 4'h5, 1, {tag, " first 5h forwarded"});
            chk(16, 1, 0, 4'h5, 1, {tag, " 14th 5h forwarded"});
        end
        chk(18, 1, 0, 4'hD, 1, {tag, " SFD Dh"});
        chk(19, 1, 0, 4'h1, 1, {tag, " data after SFD"});
        chk(21, 0, 0, 0, 0, {tag, " end"});
    endtask

    task automatic t_strip_no_sfd();
        n = 0;
        send(K_SSD, 0); send(K_DATA, 4'h5); send(K_DATA, 4'h5); send(K_DATA, 4'h7);
        send(K_DATA, 4'h5); send(K_ESD, 0); flush();
        chk(3, 0, 0, 0, 0, "R5 5h withheld");
        chk(5, 1, 0, 4'h7, 1, "R5 non-5h forwarded");
        chk(6, 1, 0, 4'h5, 1, "R5 later 5h forwarded");
    endtask

    task automatic t_code_err(input logic en, input logic sel, input string tag);
        ce_report_en = en; ce_sel = sel;
        n = 0;
        send(K_SSD, 0); send(K_DATA, 4'h1); send(K_BAD, 4'h9); send(K_DATA, 4'h2);
        send(K_ESD, 0); flush();
        chk(3, 1, 0, 4'h1, 1, {tag, " before"});
        if (en) chk(4, 1, 1, sel ? 4'h5 : 4'h6, 1, {tag, " substitute"});
        else    chk(4, 1, 0, 4'h9, 1, {tag, " raw nibble"});
        chk(5, 1, 0, 4'h2, 1, {tag, " continues"});
        chk(6, 0, 0, 0, 0, {tag, " end"});
        ce_report_en = 1'b1; ce_sel = 1'b0;
    endtask

    task automatic t_premature(input logic sel, input string tag);
        pe_sel = sel;
        n = 0;
        send(K_SSD, 0); send(K_DATA, 4'hB); send(K_DATA, 4'hC);
        send(K_IDLE, 0); send(K_IDLE, 0); send(K_DATA, 4'hE); send(K_DATA, 4'hF);
        flush();
        chk(4, 1, 0, 4'hC, 1, {tag, " last data"});
        chk(5, 1, 1, sel ? 4'h4 : 4'h6, 1, {tag, " substitute"});
        chk(6, 0, 0, 0, 0, {tag, " dv drops"});
        chk(7, 0, 0, 0, 0, {tag, " data ignored"});
        pe_sel = 1'b0;
    endtask

    task automatic t_lone_idle();
        ce_sel = 1'b1;
        n = 0;
        send(K_SSD, 0); send(K_DATA, 4'h8); send(K_IDLE, 0); send(K_DATA, 4'h9);
        send(K_ESD, 0); flush();
        chk(4, 1, 1, 4'h5, 1, "R11 lone idle as code error");
        chk(5, 1, 0, 4'h9, 1, "R11 stream continues");
        ce_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_plain();
        write_strip(1'b1);
        t_preamble(1'b1, "R4");
        t_strip_no_sfd();
        compat_mode = 1'b1;
        t_preamble(1'b0, "R6");
        write_strip(1'b0);      // R7: blocked, stored bit stays 1
        compat_mode = 1'b0;
        t_preamble(1'b1, "R7 retained");
        write_strip(1'b0);
        compat_mode = 1'b1;
        write_strip(1'b1);      // R7: blocked, stored bit stays 0
        compat_mode = 1'b0;
        t_preamble(1'b0, "R7 ignored");
        t_code_err(1'b1, 1'b0, "R8 sel0");
        t_code_err(1'b1, 1'b1, "R8 sel1");
        t_code_err(1'b0, 1'b1, "R9");
        t_premature(1'b0, "R10 sel0");
        t_premature(1'b1, "R10 sel1");
        t_lone_idle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule